// File: doc/BRIEF.md
# Dual-Channel Phase-Correct PWM Generator

This block drives two pulse-width-modulated outputs from a single shared counter that sweeps up from zero to a turn-around value and then back down to zero. Because the sweep is symmetric, each output pulse is centred on the counter's zero point, and both channels stay phase-aligned. The turn-around value is set by a resolution select of 8, 9 or 10 bits. The counter advances only on cycles where the timer clock enable `tick` is high. A prescaler, if one is needed, sits outside the block and drives `tick`.

Each channel compares the counter with the low ten bits of its own compare input. On a match it sets or clears its output, depending on the channel's two-bit compare mode and on whether the counter was counting up or down. Compare inputs are held in a shadow copy. The copy in use is refreshed only when the counter turns around at its top value, so a new duty cycle never cuts a pulse short or adds a stray edge.

Top module: `pwm_dual_phase`

## Requirements
- R1: During and right after a synchronous active-low reset, the counter is at 0 and counting up, the active compare copies are 0, and both `pwm_a` and `pwm_b` are low.
- R2: On each cycle with `tick` high, the counter moves one step: up until it reaches the top value, then down until it reaches 0, then up again. On a cycle with `tick` low, the counter and both outputs hold their values.
- R3: The top value follows `res_sel`: 2'b00 gives 255, 2'b01 gives 511, and 2'b10 or 2'b11 gives 1023. With `tick` high on every clock, the output period is 510, 1022 or 2046 clocks.
- R4: Only bits [9:0] of a 16-bit compare input take part in the match. Bits [15:10] have no effect on the output.
- R5: In mode 2'b10, a channel drives its output low when an up-step lands on the compare value, and high when a down-step lands on it.
- R6: Mode 2'b11 is the inverse of 2'b10: the output goes high on an up-step match and low on a down-step match.
- R7: In modes 2'b00 and 2'b01, the channel output is held low from the next clock on, whatever the counter and compare value are.
- R8: A channel's compare input is copied into its active value only on the tick where the counter leaves its top value. A change at any other time takes effect only after that turn-around.
- R9: A compare value equal to the top value gives no pulse. Once it is active and the counter has passed the top, a mode 2'b10 output stays low and a mode 2'b11 output stays high.
- R10: The two channels share the counter, but their compare values and modes act independently of each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Timer clock enable; the counter steps on cycles where it is high |
| res_sel | input | 2 | Resolution select (8, 9 or 10 bits) |
| cmp_a | input | 16 | Compare value for channel A; only the low 10 bits are used |
| cmp_b | input | 16 | Compare value for channel B; only the low 10 bits are used |
| mode_a | input | 2 | Compare mode for channel A |
| mode_b | input | 2 | Compare mode for channel B |
| pwm_a | output | 1 | PWM output of channel A |
| pwm_b | output | 1 | PWM output of channel B |

## Verification
Some properties are checked by assertions on every cycle:
- each tick moves the counter by exactly one;
- a cycle without a tick freezes the counter, its direction and a connected output;
- a disconnected mode forces the output low on the next clock;
- an output changes only on a compare hit;
- the active compare copy changes only at a turn-around.

The actual timing cannot be shown by these local rules. That covers the top values per resolution, the resulting periods, which bits of the compare input are ignored, when a new compare value takes effect, and the no-pulse case at the top value. The bench shows these through a behavioural reference compared on every clock, plus measured periods and scenario checks.

// File: rtl/pwm_dual_pkg.sv
// Package: shared encodings for the dual-channel phase-correct PWM.
// Assumes: the counter is at most 10 bits wide (resolution 8..10 bits).
package pwm_dual_pkg;

    // Two-bit compare mode; only the upper bit connects the output.
    typedef enum logic [1:0] {
        MODE_OFF     = 2'b00,
        MODE_OFF_ALT = 2'b01,
        MODE_NONINV  = 2'b10,
        MODE_INV     = 2'b11
    } cmp_mode_e;

    // Direction of the counter sweep.
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } sweep_dir_e;

endpackage

// File: rtl/pwm_updown_counter.sv
// Module: shared up/down sweep counter.
// What it does: counts 0 -> top -> 0 on each tick. It presents its next
// value and direction combinationally, so that the channels can register
// their outputs on the same edge. It also flags the turn-around at top,
// which is when the compare shadows are loaded.
// Assumes: res_sel may change at any time; a count above a new top
// simply turns down on the next up-step.
module pwm_updown_counter
    import pwm_dual_pkg::*;
#(
    parameter int unsigned BASE_RES = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic [1:0]                 res_sel,
    output logic [BASE_RES+1:0]        cnt_nxt,
    output sweep_dir_e                 dir_nxt,
    output logic                       turn_top
);

    localparam int unsigned CNT_W = BASE_RES + 2;

    logic [CNT_W-1:0] cnt_q;
    sweep_dir_e       dir_q;
    logic [CNT_W-1:0] top_val;

    // Select the top value from the resolution setting.
    always_comb begin
        case (res_sel)
            2'b00:   top_val = {CNT_W{1'b1}} >> 2;
            2'b01:   top_val = {CNT_W{1'b1}} >> 1;
            default: top_val = {CNT_W{1'b1}};
        endcase
    end

    // Next count, next direction and the turn-at-top strobe.
    always_comb begin
        cnt_nxt  = cnt_q;
        dir_nxt  = dir_q;
        turn_top = 1'b0;
        if (tick) begin
            if (dir_q == DIR_UP) begin
                if (cnt_q >= top_val) begin
                    cnt_nxt  = cnt_q - 1'b1;
                    dir_nxt  = DIR_DOWN;
                    turn_top = 1'b1;
                end else begin
                    cnt_nxt = cnt_q + 1'b1;
                end
            end else begin
                if (cnt_q == '0) begin
                    cnt_nxt = {{(CNT_W-1){1'b0}}, 1'b1};
                    dir_nxt = DIR_UP;
                end else begin
                    cnt_nxt = cnt_q - 1'b1;
                end
            end
        end
    end

    // Counter state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dir_q <= DIR_UP;
        end else begin
            cnt_q <= cnt_nxt;
            dir_q <= dir_nxt;
        end
    end

    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)) ||
                 (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q) && $stable(dir_q));

    // R2
    zero_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q == '0) |=> (dir_q == DIR_UP) && (cnt_q == CNT_W'(1)));

endmodule

// File: rtl/pwm_cmp_channel.sv
// Module: one compare channel with a double-buffered compare value.
// What it does: loads its active compare value from the input when the
// counter turns at top. It then sets or clears a registered output when
// the counter's next value equals that active value, using the step
// direction and the mode.
// Assumes: cnt_nxt, dir_nxt and load come from the shared counter for
// the same clock edge.
module pwm_cmp_channel
    import pwm_dual_pkg::*;
#(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] cmp_in,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  sweep_dir_e       dir_nxt,
    input  logic             load,
    output logic             pwm_out
);

    logic [CNT_W-1:0] act_q;
    logic             hit;
    logic             connected;

    assign connected = mode[1];
    assign hit       = tick && (cnt_nxt == act_q);

    // Active compare copy, refreshed only at the turn-around at top.
    always_ff @(posedge clk) begin
        if (!rst_n)     act_q <= '0;
        else if (load)  act_q <= cmp_in;
    end

    // Output register: forced low when disconnected, else set or clear on a hit.
    always_ff @(posedge clk) begin
        if (!rst_n)          pwm_out <= 1'b0;
        else if (!connected) pwm_out <= 1'b0;
        else if (hit)        pwm_out <= (dir_nxt == DIR_UP) ? mode[0] : ~mode[0];
    end

    // R7
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode[1] |=> !pwm_out);

    // R8
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(act_q));

    // R2
    no_tick_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && mode[1]) |=> $stable(pwm_out));

    // R5 R6
    edge_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && !hit) |=> $stable(pwm_out));

endmodule

// File: rtl/pwm_dual_phase.sv
// Module: top of the dual-channel phase-correct PWM.
// What it does: one shared up/down counter feeds two independent compare
// channels, which are built by a generate loop.
// Assumes: CMP_W >= BASE_RES + 2; compare bits above the counter width
// are ignored.
module pwm_dual_phase
    import pwm_dual_pkg::*;
#(
    parameter int unsigned BASE_RES = 8,
    parameter int unsigned CMP_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [1:0]       res_sel,
    input  logic [CMP_W-1:0] cmp_a,
    input  logic [CMP_W-1:0] cmp_b,
    input  logic [1:0]       mode_a,
    input  logic [1:0]       mode_b,
    output logic             pwm_a,
    output logic             pwm_b
);

    localparam int unsigned CNT_W = BASE_RES + 2;
    localparam int unsigned N_CH  = 2;

    logic [CNT_W-1:0] cnt_nxt;
    sweep_dir_e       dir_nxt;
    logic             turn_top;

    logic [CNT_W-1:0] ch_cmp  [N_CH];
    logic [1:0]       ch_mode [N_CH];
    logic [N_CH-1:0]  ch_out;
    logic             unused_cmp_hi;

    // Gather the per-channel inputs into arrays.
    always_comb begin
        ch_cmp[0]  = cmp_a[CNT_W-1:0];
        ch_cmp[1]  = cmp_b[CNT_W-1:0];
        ch_mode[0] = mode_a;
        ch_mode[1] = mode_b;
    end

    assign unused_cmp_hi = ^{cmp_a[CMP_W-1:CNT_W], cmp_b[CMP_W-1:CNT_W]};

    pwm_updown_counter #(
        .BASE_RES (BASE_RES)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .res_sel  (res_sel),
        .cnt_nxt  (cnt_nxt),
        .dir_nxt  (dir_nxt),
        .turn_top (turn_top)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        pwm_cmp_channel #(
            .CNT_W (CNT_W)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .cmp_in  (ch_cmp[g]),
            .mode    (ch_mode[g]),
            .cnt_nxt (cnt_nxt),
            .dir_nxt (dir_nxt),
            .load    (turn_top),
            .pwm_out (ch_out[g])
        );
    end

    assign pwm_a = ch_out[0];
    assign pwm_b = ch_out[1];

    // R1
    reset_low_chk: assert property (@(posedge clk)
        !rst_n |=> (ch_out == '0));

endmodule

// File: tb/pwm_dual_phase_bench.sv
`timescale 1ns/1ps
module pwm_dual_phase_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick;
    logic [1:0]  res_sel;
    logic [15:0] cmp_a, cmp_b;
    logic [1:0]  mode_a, mode_b;
    logic        pwm_a, pwm_b;

    always #4 clk = ~clk;   // 125 MHz

    pwm_dual_phase u_pwm_dual_phase (
        .clk(clk), .rst_n(rst_n), .tick(tick), .res_sel(res_sel),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .mode_a(mode_a), .mode_b(mode_b),
        .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    int    compared   = 0;
    int    mismatched = 0;
    string cur_req    = "R1";
    int    tick_div   = 1;
    int    tick_cnt   = 0;
    bit    done       = 0;
    bit    live       = 0;

    // Behavioural reference state.
    int m_cnt, m_top, m_nc;
    bit m_up, m_nup, m_ld;
    int m_act [2];
    bit m_q   [2];
    int m_mode[2];
    int m_cmp [2];

    task automatic chk(string req, logic act, logic exp, string what);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model, one step per clock edge.
    always @(posedge clk) begin
        m_mode[0] = mode_a; m_mode[1] = mode_b;
        m_cmp[0]  = cmp_a % 1024; m_cmp[1] = cmp_b % 1024;
        if (!rst_n) begin
            m_cnt = 0; m_up = 1;
            m_act[0] = 0; m_act[1] = 0; m_q[0] = 0; m_q[1] = 0;
        end else begin
            m_top = (res_sel == 2'd0) ? 255 : (res_sel == 2'd1) ? 511 : 1023;
            m_nc = m_cnt; m_nup = m_up; m_ld = 0;
            if (tick) begin
                if (m_up) begin
                    if (m_cnt >= m_top) begin m_nc = m_cnt - 1; m_nup = 0; m_ld = 1; end
                    else m_nc = m_cnt + 1;
                end else begin
                    if (m_cnt == 0) begin m_nc = 1; m_nup = 1; end
                    else m_nc = m_cnt - 1;
                end
            end
            for (int c = 0; c < 2; c++) begin
                if (m_mode[c] < 2) m_q[c] = 0;
                else if (tick && m_nc == m_act[c])
                    m_q[c] = m_nup ? (m_mode[c] == 3) : (m_mode[c] == 2);
                if (m_ld) m_act[c] = m_cmp[c];
            end
            m_cnt = m_nc; m_up = m_nup;
        end
    end

    // Compare against the reference each cycle, then drive the next tick.
    always @(negedge clk) begin
        if (live) begin
            chk(cur_req, pwm_a, m_q[0], "pwm_a vs model");
            chk(cur_req, pwm_b, m_q[1], "pwm_b vs model");
        end
        tick_cnt++;
        tick = (tick_div <= 1) || (tick_cnt % tick_div == 0);
    end

    // Clocks between two rising edges of pwm_a.
    task automatic meas_period(output int n);
        logic prev;
        n = 0;
        prev = pwm_a;
        forever begin
            @(negedge clk);
            if (!prev && pwm_a) break;
            prev = pwm_a;
        end
        prev = pwm_a;
        forever begin
            @(negedge clk);
            n++;
            if (!prev && pwm_a) break;
            prev = pwm_a;
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int per;
        rst_n = 0; tick = 1; res_sel = 2'b00;
        cmp_a = 16'd100; cmp_b = 16'd200; mode_a = 2'b10; mode_b = 2'b11;
        repeat (3) @(negedge clk);
        chk("R1", pwm_a, 1'b0, "pwm_a in reset");
        chk("R1", pwm_b, 1'b0, "pwm_b in reset");
        rst_n = 1;
        @(negedge clk);
        chk("R1", pwm_a, 1'b0, "pwm_a after reset");
        chk("R1", pwm_b, 1'b0, "pwm_b after reset");
        live = 1;

        // R2 R5 R6 R10: 8-bit sweep, both modes, independent compares.
        cur_req = "R2/R5/R6/R10";
        repeat (1200) @(negedge clk);
        cur_req = "R3";
        meas_period(per);
        chk("R3", per == 510, 1'b1, "8-bit period is 510");

        // R4: upper compare bits ignored, so A tracks B.
        cur_req = "R4";
        cmp_a = 16'hA864; cmp_b = 16'd100; mode_b = 2'b10;
        repeat (600) @(negedge clk);
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (i % 50 == 0) chk("R4", pwm_a, pwm_b, "pwm_a equals pwm_b");
        end

        // R7: disconnected modes hold low.
        cur_req = "R7";
        mode_a = 2'b00; mode_b = 2'b01;
        @(negedge clk);
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (i % 60 == 0) begin
                chk("R7", pwm_a, 1'b0, "mode 00 low");
                chk("R7", pwm_b, 1'b0, "mode 01 low");
            end
        end

        // R9: compare at top gives no pulse.
        cur_req = "R9";
        mode_a = 2'b10; mode_b = 2'b11; cmp_a = 16'd255; cmp_b = 16'd255;
        repeat (1100) @(negedge clk);
        for (int i = 0; i < 520; i++) begin
            @(negedge clk);
            if (i % 40 == 0) begin
                chk("R9", pwm_a, 1'b0, "mode 10 at top stays low");
                chk("R9", pwm_b, 1'b1, "mode 11 at top stays high");
            end
        end

        // R8: compare changes at arbitrary points take effect at turn-around.
        cur_req = "R8";
        for (int i = 0; i < 16; i++) begin
            cmp_a = 16'((i * 37 + 11) % 256);
            cmp_b = 16'((i * 91 + 5) % 256);
            repeat (137) @(negedge clk);
        end

        // R3: 9-bit resolution period.
        cur_req = "R3";
        cmp_a = 16'd100; cmp_b = 16'd300; res_sel = 2'b01;
        repeat (2100) @(negedge clk);
        meas_period(per);
        chk("R3", per == 1022, 1'b1, "9-bit period is 1022");

        // R2 R3: 10-bit with a tick every third clock.
        cur_req = "R2/R3";
        res_sel = 2'b10; cmp_b = 16'd700; tick_div = 3;
        repeat (6200) @(negedge clk);
        meas_period(per);
        chk("R3", per == 6138, 1'b1, "10-bit period at one tick in three");

        // R3: encoding 11 behaves as 10-bit.
        tick_div = 1; res_sel = 2'b11;
        repeat (2100) @(negedge clk);
        meas_period(per);
        chk("R3", per == 2046, 1'b1, "res 11 period is 2046");

        done = 1;
        summary();
        $finish;
    end

endmodule